// File: doc/BRIEF.md
# Page-Granular RAM Sizing Tester

This block is a memory self-test engine that finds how much RAM is fitted behind a simple synchronous SRAM port. After a start pulse it walks upward from a fixed base page, one page at a time. For every byte of a page it writes an alternating-bit pattern, then does an unrelated read-modify-write of address 0, then reads the byte back and compares it. It does this once with 0xAA and once with 0x55.

The dummy access between a write and its read-back changes the value left on the data bus. A missing memory that only echoes the last bus value therefore cannot look like a pass. The dummy write puts back the value it just read, so address 0 keeps its contents. The walk ends at the first byte that fails, or after the last page of the address space. The engine then reports the highest page that passed in full and raises a done flag. A failure in the very first page reports the page below the base and also raises a fail flag.

The engine is a single state machine with seven states:
- Idle: after reset.
- Write: pattern write to the byte under test.
- DummyRead: read of address 0.
- DummyWrite: write-back to address 0.
- Read: read-back of the byte under test.
- Check: compare.
- Done: result held.

Its transitions are:
- Idle→Write and Done→Write on start.
- Write→DummyRead→DummyWrite→Read→Check, one cycle each.
- Check→Write, either to the 0x55 phase or to the next byte.
- Check→Done on a mismatch, or after the last byte of the last page.

Top module: `ram_sizer`

## Requirements
- R1: While reset is asserted and after it is released, `run_done`, `size_fail` and `mem_we` are 0 and `top_page` is 0.
- R2: A start pulse seen in Idle or Done gives, in the next cycle, a write of 0xAA to byte 0 of page BASE_PAGE (byte address BASE_PAGE × 2^OFFS_W).
- R3: The steps for each byte take one cycle each, in this order: write 0xAA, read address 0, write address 0, read the byte, compare; then the same five steps with 0x55. The next byte's 0xAA write follows at once.
- R4: The write to address 0 always follows a read of address 0 in the cycle before, and it stores the value that read returned, so address 0 ends the run unchanged.
- R5: Bytes are tested at increasing addresses, from byte 0 to the last byte of a page and then into the next higher page. If every page up to the top of the address space passes, `top_page` is 2^(ADDR_W−OFFS_W)−1 and `size_fail` is 0.
- R6: The walk stops at the first byte whose read-back differs from its pattern. `top_page` is then the highest page whose every byte passed both patterns.
- R7: If a byte in the base page fails, `top_page` is BASE_PAGE−1 and `size_fail` is 1. `size_fail` is only ever 1 while `run_done` is 1.
- R8: `run_done` and `top_page` hold their values until the next start pulse. A start pulse during a walk is ignored.
- R9: A missing memory region whose reads return the last value seen on the data bus is reported as failing. The value at address 0 must not be 0xAA or 0x55.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle pulse that starts a sizing walk |
| mem_addr | output | ADDR_W | Byte address to the SRAM |
| mem_wdata | output | DATA_W | Write data to the SRAM |
| mem_we | output | 1 | Write enable, one write per cycle |
| mem_rdata | input | DATA_W | Read data, valid one cycle after the address |
| run_done | output | 1 | High from the end of a walk until the next start |
| top_page | output | ADDR_W−OFFS_W | Highest page that passed |
| size_fail | output | 1 | High when even the base page failed |

## Verification
A wrong state or a wrong cursor shows up on the SRAM port within one cycle. The write-enable and address pattern follows a fixed five-cycle rhythm per pattern, so a skipped or repeated state breaks it at once. A cursor error would either repeat a byte or skip ahead to another page. An early or late stop, or a page recorded at the wrong moment, shows up only in `top_page` when `run_done` rises. For that reason the results are compared against memories of several fitted sizes and with injected faults at known bytes.

// File: rtl/rs_pkg.sv
package rs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WRITE,
        ST_DUM_RD,
        ST_DUM_WR,
        ST_READ,
        ST_CHECK,
        ST_DONE
    } rs_state_e;
endpackage

// File: rtl/rs_cursor.sv
module rs_cursor #(
    parameter int PAGE_W    = 8,
    parameter int OFFS_W    = 8,
    parameter int BASE_PAGE = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              step,
    output logic [PAGE_W-1:0] page,
    output logic [OFFS_W-1:0] offs,
    output logic              last_byte,
    output logic              last_page
);
    localparam logic [PAGE_W-1:0] START_PAGE = PAGE_W'(BASE_PAGE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page <= START_PAGE;
            offs <= '0;
        end else if (clr) begin
            page <= START_PAGE;
            offs <= '0;
        end else if (step) begin
            {page, offs} <= {page, offs} + 1'b1;
        end
    end

    assign last_byte = &offs;
    assign last_page = &page;
endmodule

// File: rtl/rs_pattern.sv
module rs_pattern #(
    parameter int DATA_W = 8
) (
    input  logic              phase,
    input  logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] pat,
    output logic              match
);
    localparam logic [DATA_W-1:0] PAT_HI = {(DATA_W/2){2'b10}};
    localparam logic [DATA_W-1:0] PAT_LO = {(DATA_W/2){2'b01}};

    assign pat   = phase ? PAT_LO : PAT_HI;
    assign match = (rdata == pat);
endmodule

// File: rtl/rs_fsm.sv
module rs_fsm
    import rs_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start,
    input  logic      match,
    input  logic      last_byte,
    input  logic      last_page,
    output rs_state_e state,
    output logic      phase,
    output logic      cur_clr,
    output logic      cur_step,
    output logic      rec_page,
    output logic      fail_stop
);
    rs_state_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE, ST_DONE: if (start) nxt = ST_WRITE;
            ST_WRITE:  nxt = ST_DUM_RD;
            ST_DUM_RD: nxt = ST_DUM_WR;
            ST_DUM_WR: nxt = ST_READ;
            ST_READ:   nxt = ST_CHECK;
            ST_CHECK: begin
                if (!match)                                  nxt = ST_DONE;
                else if (phase && last_byte && last_page)    nxt = ST_DONE;
                else                                         nxt = ST_WRITE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            phase <= 1'b0;
        end else begin
            state <= nxt;
            if (cur_clr)
                phase <= 1'b0;
            else if (state == ST_CHECK && match)
                phase <= ~phase;
        end
    end

    always_comb begin
        cur_clr   = (state == ST_IDLE || state == ST_DONE) && start;
        rec_page  = (state == ST_CHECK) && match && phase && last_byte;
        cur_step  = (state == ST_CHECK) && match && phase && !(last_byte && last_page);
        fail_stop = (state == ST_CHECK) && !match;
    end
endmodule

// File: rtl/ram_sizer.sv
module ram_sizer
    import rs_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 8,
    parameter int OFFS_W    = 8,
    parameter int BASE_PAGE = 24
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    output logic [ADDR_W-1:0]        mem_addr,
    output logic [DATA_W-1:0]        mem_wdata,
    output logic                     mem_we,
    input  logic [DATA_W-1:0]        mem_rdata,
    output logic                     run_done,
    output logic [ADDR_W-OFFS_W-1:0] top_page,
    output logic                     size_fail
);
    localparam int PAGE_W = ADDR_W - OFFS_W;
    localparam logic [PAGE_W-1:0] BELOW_BASE = PAGE_W'(BASE_PAGE - 1);
    localparam logic [PAGE_W-1:0] BASE_P     = PAGE_W'(BASE_PAGE);

    rs_state_e         state;
    logic              phase, cur_clr, cur_step, rec_page, fail_stop;
    logic              last_byte, last_page, match;
    logic [PAGE_W-1:0] page;
    logic [OFFS_W-1:0] offs;
    logic [DATA_W-1:0] pat;

    rs_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .match(match),
        .last_byte(last_byte), .last_page(last_page), .state(state),
        .phase(phase), .cur_clr(cur_clr), .cur_step(cur_step),
        .rec_page(rec_page), .fail_stop(fail_stop)
    );

    rs_cursor #(.PAGE_W(PAGE_W), .OFFS_W(OFFS_W), .BASE_PAGE(BASE_PAGE)) u_cur (
        .clk(clk), .rst_n(rst_n), .clr(cur_clr), .step(cur_step),
        .page(page), .offs(offs), .last_byte(last_byte), .last_page(last_page)
    );

    rs_pattern #(.DATA_W(DATA_W)) u_pat (
        .phase(phase), .rdata(mem_rdata), .pat(pat), .match(match)
    );

    always_comb begin
        mem_we    = (state == ST_WRITE) || (state == ST_DUM_WR);
        mem_addr  = (state == ST_DUM_RD || state == ST_DUM_WR) ? '0 : {page, offs};
        mem_wdata = (state == ST_DUM_WR) ? mem_rdata : pat;
        run_done  = (state == ST_DONE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_page  <= '0;
            size_fail <= 1'b0;
        end else if (cur_clr) begin
            top_page  <= BELOW_BASE;
            size_fail <= 1'b0;
        end else begin
            if (rec_page)
                top_page <= page;
            if (fail_stop && page == BASE_P)
                size_fail <= 1'b1;
        end
    end
endmodule

// File: rtl/rs_checks.sv
module rs_checks #(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 8,
    parameter int OFFS_W    = 8,
    parameter int BASE_PAGE = 24
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     start,
    input logic [ADDR_W-1:0]        mem_addr,
    input logic [DATA_W-1:0]        mem_wdata,
    input logic                     mem_we,
    input logic                     run_done,
    input logic [ADDR_W-OFFS_W-1:0] top_page,
    input logic                     size_fail
);
    localparam logic [ADDR_W-1:0] FLOOR = ADDR_W'(BASE_PAGE) << OFFS_W;
    localparam logic [DATA_W-1:0] P_HI  = {(DATA_W/2){2'b10}};
    localparam logic [DATA_W-1:0] P_LO  = {(DATA_W/2){2'b01}};

    p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!run_done && !mem_we));

    p_test_write_then_dummy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_addr != '0) |=> (!mem_we && mem_addr == '0));

    p_dummy_write_after_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_addr == '0) |-> $past(!mem_we && mem_addr == '0));

    p_pattern_values_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_addr != '0) |-> (mem_wdata == P_HI || mem_wdata == P_LO));

    p_addr_above_base_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_addr != '0) |-> (mem_addr >= FLOOR));

    p_fail_only_when_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        size_fail |-> run_done);

    p_done_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (run_done && !start) |=> (run_done && $stable(top_page)));

    p_done_drops_on_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (run_done && start) |=> (!run_done && mem_we));
endmodule

bind ram_sizer rs_checks #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFFS_W(OFFS_W), .BASE_PAGE(BASE_PAGE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .run_done(run_done),
    .top_page(top_page), .size_fail(size_fail)
);

// File: tb/sim_ram_sizer.sv
`timescale 1ns/1ps
module sim_ram_sizer;
    localparam int ADDR_W = 10;
    localparam int DATA_W = 8;
    localparam int OFFS_W = 4;
    localparam int BASE   = 3;
    localparam int PAGE_W = ADDR_W - OFFS_W;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam logic [7:0] ZERO_VAL = 8'h3C;

    // columns: fitted pages, fault enable, fault address, expected top, expected fail, mid-run start
    localparam int NV = 6;
    localparam int VEC [NV][6] = '{
        '{64, 0,   0, 63, 0, 0},
        '{20, 0,   0, 19, 0, 1},
        '{ 3, 0,   0,  2, 1, 0},
        '{ 4, 0,   0,  3, 0, 0},
        '{64, 1, 167,  9, 0, 0},
        '{64, 1,  63,  2, 1, 0}
    };

    logic clk = 0, rst_n = 0, start = 0;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata, mem_rdata;
    logic mem_we, run_done, size_fail;
    logic [PAGE_W-1:0] top_page;

    int total = 0, bad = 0;
    int fit_lim = DEPTH, fault_en = 0, fault_addr = 0;
    logic [7:0] mem [DEPTH];
    logic [7:0] bus_last = 8'h00;

    always #2 clk = ~clk;

    ram_sizer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFFS_W(OFFS_W), .BASE_PAGE(BASE)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_rdata(mem_rdata),
        .run_done(run_done), .top_page(top_page), .size_fail(size_fail)
    );

    // SRAM model: unfitted reads echo the last bus value
    always @(posedge clk) begin
        if (mem_we) begin
            if (int'(mem_addr) < fit_lim)
                mem[mem_addr] <= (fault_en != 0 && int'(mem_addr) == fault_addr)
                                 ? (mem_wdata & 8'hFE) : mem_wdata;
            bus_last <= mem_wdata;
        end else if (int'(mem_addr) < fit_lim) begin
            bus_last <= mem[mem_addr];
        end
        mem_rdata <= (int'(mem_addr) < fit_lim) ? mem[mem_addr] : bus_last;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1;
        @(negedge clk) start = 0;
    endtask

    task automatic wait_done(output bit ok);
        ok = 0;
        for (int i = 0; i < 20000; i++) begin
            if (run_done) begin ok = 1; break; end
            @(negedge clk);
        end
    endtask

    task automatic prep(input int fit, input int fen, input int fad);
        for (int a = 0; a < DEPTH; a++) mem[a] = 8'h00;
        mem[0] = ZERO_VAL;
        fit_lim = fit << OFFS_W;
        fault_en = fen;
        fault_addr = fad;
    endtask

    initial begin
        #200000;
        bad++; total++;
        $display("FAIL watchdog R8 actual=%0d expected=%0d", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        bit ok;
        prep(64, 0, 0);
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!run_done && !size_fail && !mem_we && top_page == 0, "R1 reset",
            {run_done, size_fail, mem_we}, 0);
        rst_n = 1;
        @(negedge clk);
        chk(!run_done && !mem_we && top_page == 0, "R1 after release", top_page, 0);

        // R2/R3: cycle-exact start of the walk
        @(negedge clk) start = 1;
        @(negedge clk) start = 0;
        chk(mem_we && mem_addr == BASE * 16 && mem_wdata == 8'hAA, "R2 first write",
            mem_addr, BASE * 16);
        @(negedge clk);
        chk(!mem_we && mem_addr == 0, "R3 dummy read", mem_addr, 0);
        @(negedge clk);
        chk(mem_we && mem_addr == 0 && mem_wdata == ZERO_VAL, "R4 dummy write-back",
            mem_wdata, ZERO_VAL);
        @(negedge clk);
        chk(!mem_we && mem_addr == BASE * 16, "R3 read-back", mem_addr, BASE * 16);
        @(negedge clk);
        chk(!mem_we, "R3 compare cycle", mem_we, 0);
        @(negedge clk);
        chk(mem_we && mem_addr == BASE * 16 && mem_wdata == 8'h55, "R3 second pattern",
            mem_wdata, 8'h55);
        repeat (5) @(negedge clk);
        chk(mem_we && mem_addr == BASE * 16 + 1 && mem_wdata == 8'hAA, "R5 next byte",
            mem_addr, BASE * 16 + 1);
        wait_done(ok);
        chk(ok, "R5 directed run finishes", ok, 1);

        // table-driven sizing runs
        for (int v = 0; v < NV; v++) begin
            prep(VEC[v][0], VEC[v][1], VEC[v][2]);
            pulse_start();
            if (VEC[v][5] != 0) begin
                repeat (100) @(negedge clk);
                pulse_start();                 // R8: ignored mid-run
                chk(!run_done, "R8 start mid-run ignored", run_done, 0);
            end
            wait_done(ok);
            chk(ok && top_page == VEC[v][3], (v == 1) ? "R9 residue top page" :
                (VEC[v][1] != 0) ? "R6 fault top page" : "R5 top page",
                top_page, VEC[v][3]);
            chk(size_fail == VEC[v][4], "R7 fail flag", size_fail, VEC[v][4]);
            chk(mem[0] == ZERO_VAL, "R4 address 0 restored", mem[0], ZERO_VAL);
            repeat (20) @(negedge clk);
            chk(run_done && top_page == VEC[v][3], "R8 done held", top_page, VEC[v][3]);
        end

        // R7/R8: restart from a failed state clears fail and re-reports
        prep(64, 0, 0);
        @(negedge clk) start = 1;
        @(negedge clk) start = 0;
        chk(!run_done && !size_fail && top_page == BASE - 1, "R8 restart clears",
            top_page, BASE - 1);
        wait_done(ok);
        chk(ok && top_page == 63 && !size_fail, "R7 fail cleared on pass", top_page, 63);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule